// File: doc/BRIEF.md
# Outbound Address Translation Window Bank

This block holds a small bank of programmable translation windows for a PCIe root port. There is one set of windows for each direction, inbound and outbound. Software reaches every window through one indirect selector: it picks a direction and an index, and then accesses that window's control, base, limit and target words at fixed offsets. Only the outbound windows take part in lookups. The inbound set is storage that software can program and read back.

A CPU-side address enters on a valid/ready request stream. One cycle later a result appears on a valid/ready result stream. The result says whether an enabled outbound window covers the address. A memory-type window gives back a translated address. A configuration-type window gives back a bus number, a device/function number and a register offset into the 4 KB extended configuration space.

Settings that software stages in a window's registers reach the lookup only when that window's second control word is written. Software can therefore rewrite base, limit and target without the lookup ever seeing a half-built window. The request side stalls only while a result is held and not taken: `req_ready` is high when `res_valid` is low or `res_ready` is high. A result stays stable until the consumer accepts it.

Top module: `xlat_window_unit`

## Requirements
- R1: The selector word at offset 0x900 has the direction in bit 31 (1 = inbound, 0 = outbound) and the window index in bits [1:0]. When it is written, the index is masked to NWIN-1 and every other bit is forced to zero. A read returns the masked value.
- R2: Window words act on the selected window. These are control 1 (0x904), control 2 (0x908), base low (0x90C), base high (0x910), limit (0x914), target low (0x918) and target high (0x91C). A read returns the stored value. Unmapped offsets read as zero.
- R3: Writing one 32-bit half of base or target changes only that half and keeps the other half.
- R4: After reset, every window reads base 0, target 0, limit 0xFFFFFFFF and control 1 = 0. Control 2 reads 0 for every window except inbound window 0, which reads 0x80000000 (enabled). No outbound lookup hits.
- R5: Writing base, limit, target or control 1 has no effect on lookups. A write to an outbound window's control 2 copies that window's enable (control 2 bit 31), type, base, limit and target into the live lookup copy.
- R6: A window hits when it is enabled and base <= address < base + size, where size = limit - base + 1. The limit is zero-extended from 32 bits and the arithmetic is 64-bit.
- R7: A memory window (control 1 bits [4:0] equal to 0) hits with res_cfg=0 and res_addr = target + (address - base). In that case res_bus, res_devfn and res_reg are zero.
- R8: A configuration window (control 1 bits [4:0] not zero) hits with res_cfg=1 and res_addr=0. res_bus comes from target bits [31:24], res_devfn from target bits [23:16], and res_reg = (address - base) bits [11:0].
- R9: When several enabled outbound windows hit, the window with the lowest index supplies the result.
- R10: A lookup that no window hits returns res_hit=0, and every other result field is zero.
- R11: A request accepted in one cycle gives res_valid in the next cycle. While res_valid is high and res_ready is low, the result holds stable and req_ready is low.
- R12: Inbound window contents, enabled or not, never change an outbound lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Register read data for reg_addr (combinational) |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted when high with req_valid |
| req_addr | input | 64 | CPU-side address to translate |
| res_valid | output | 1 | Lookup result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_hit | output | 1 | An outbound window matched |
| res_cfg | output | 1 | The matching window is configuration type |
| res_addr | output | 64 | Translated memory address |
| res_bus | output | 8 | Configuration target bus |
| res_devfn | output | 8 | Configuration target device/function |
| res_reg | output | 12 | Configuration register offset |

## Verification
A corrupted register word shows on reg_rd_data in the same cycle that its offset is presented. A corrupted live copy stays hidden until a lookup lands in the affected window, and it then shows in the very next result as a wrong hit, a wrong type or a wrong address. The bench therefore probes both edges of every programmed window, the overlap between two windows and the gaps around them. A wrongly timed commit only shows as a lookup that answers with new settings before control 2 is written, so the bench checks lookups both before and after that write.

// File: rtl/xwu_pkg.sv
package xwu_pkg;
  localparam int XW_AW = 64;

  localparam logic [11:0] OFS_SELECT  = 12'h900;
  localparam logic [11:0] OFS_CTL1    = 12'h904;
  localparam logic [11:0] OFS_CTL2    = 12'h908;
  localparam logic [11:0] OFS_BASE_LO = 12'h90C;
  localparam logic [11:0] OFS_BASE_HI = 12'h910;
  localparam logic [11:0] OFS_LIMIT   = 12'h914;
  localparam logic [11:0] OFS_TGT_LO  = 12'h918;
  localparam logic [11:0] OFS_TGT_HI  = 12'h91C;

  localparam int DIR_OUT = 0;
  localparam int DIR_IN  = 1;

  // Snapshot of one outbound window as seen by the lookup path.
  typedef struct packed {
    logic             en;
    logic             cfg;
    logic [XW_AW-1:0] base;
    logic [XW_AW-1:0] size;
    logic [XW_AW-1:0] target;
  } live_win_t;
endpackage

// File: rtl/xwu_regs.sv
module xwu_regs
  import xwu_pkg::*;
#(
  parameter int NWIN = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [11:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output live_win_t   live [NWIN]
);
  localparam int IW = (NWIN > 1) ? $clog2(NWIN) : 1;

  logic          sel_dir;
  logic [IW-1:0] sel_idx;

  logic [31:0]      ctl1  [2][NWIN];
  logic [31:0]      ctl2  [2][NWIN];
  logic [XW_AW-1:0] base  [2][NWIN];
  logic [31:0]      limit [2][NWIN];
  logic [XW_AW-1:0] tgt   [2][NWIN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_dir <= 1'b0;
      sel_idx <= '0;
      for (int d = 0; d < 2; d++) begin
        for (int w = 0; w < NWIN; w++) begin
          ctl1[d][w]  <= '0;
          ctl2[d][w]  <= (d == DIR_IN && w == 0) ? 32'h8000_0000 : 32'h0;
          base[d][w]  <= '0;
          limit[d][w] <= 32'hFFFF_FFFF;
          tgt[d][w]   <= '0;
        end
      end
      for (int w = 0; w < NWIN; w++) live[w] <= '0;
    end else if (wr_en) begin
      unique case (addr)
        OFS_SELECT: begin
          sel_dir <= wdata[31];
          sel_idx <= wdata[IW-1:0];
        end
        OFS_CTL1:    ctl1[sel_dir][sel_idx] <= wdata;
        OFS_CTL2: begin
          ctl2[sel_dir][sel_idx] <= wdata;
          if (sel_dir == 1'(DIR_OUT)) begin
            live[sel_idx].en     <= wdata[31];
            live[sel_idx].cfg    <= |ctl1[DIR_OUT][sel_idx][4:0];
            live[sel_idx].base   <= base[DIR_OUT][sel_idx];
            live[sel_idx].size   <= {32'h0, limit[DIR_OUT][sel_idx]}
                                    - base[DIR_OUT][sel_idx] + 64'd1;
            live[sel_idx].target <= tgt[DIR_OUT][sel_idx];
          end
        end
        OFS_BASE_LO: base[sel_dir][sel_idx][31:0]  <= wdata;
        OFS_BASE_HI: base[sel_dir][sel_idx][63:32] <= wdata;
        OFS_LIMIT:   limit[sel_dir][sel_idx]       <= wdata;
        OFS_TGT_LO:  tgt[sel_dir][sel_idx][31:0]   <= wdata;
        OFS_TGT_HI:  tgt[sel_dir][sel_idx][63:32]  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr)
      OFS_SELECT: begin
        rdata = '0;
        rdata[31] = sel_dir;
        rdata[IW-1:0] = sel_idx;
      end
      OFS_CTL1:    rdata = ctl1[sel_dir][sel_idx];
      OFS_CTL2:    rdata = ctl2[sel_dir][sel_idx];
      OFS_BASE_LO: rdata = base[sel_dir][sel_idx][31:0];
      OFS_BASE_HI: rdata = base[sel_dir][sel_idx][63:32];
      OFS_LIMIT:   rdata = limit[sel_dir][sel_idx];
      OFS_TGT_LO:  rdata = tgt[sel_dir][sel_idx][31:0];
      OFS_TGT_HI:  rdata = tgt[sel_dir][sel_idx][63:32];
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/xwu_match.sv
module xwu_match
  import xwu_pkg::*;
(
  input  live_win_t        win,
  input  logic [XW_AW-1:0] addr,
  output logic             hit,
  output logic [XW_AW-1:0] offset,
  output logic [XW_AW-1:0] xaddr
);
  always_comb begin
    offset = addr - win.base;
    hit    = win.en && (addr >= win.base) && (offset < win.size);
    xaddr  = win.target + offset;
  end
endmodule

// File: rtl/xlat_window_unit.sv
module xlat_window_unit
  import xwu_pkg::*;
#(
  parameter int NWIN = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wr_data,
  output logic [31:0] reg_rd_data,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [63:0] req_addr,
  output logic        res_valid,
  input  logic        res_ready,
  output logic        res_hit,
  output logic        res_cfg,
  output logic [63:0] res_addr,
  output logic [7:0]  res_bus,
  output logic [7:0]  res_devfn,
  output logic [11:0] res_reg
);
  live_win_t        live   [NWIN];
  logic [NWIN-1:0]  hits;
  logic [XW_AW-1:0] offs   [NWIN];
  logic [XW_AW-1:0] xaddrs [NWIN];

  xwu_regs #(.NWIN(NWIN)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr_en),
    .addr  (reg_addr),
    .wdata (reg_wr_data),
    .rdata (reg_rd_data),
    .live  (live)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    xwu_match u_match (
      .win    (live[w]),
      .addr   (req_addr),
      .hit    (hits[w]),
      .offset (offs[w]),
      .xaddr  (xaddrs[w])
    );
  end

  // Lowest index wins: scan from the top so the last assignment is the lowest.
  logic             n_hit, n_cfg;
  logic [XW_AW-1:0] n_addr, n_off, n_tgt;
  always_comb begin
    n_hit  = 1'b0;
    n_cfg  = 1'b0;
    n_addr = '0;
    n_off  = '0;
    n_tgt  = '0;
    for (int w = NWIN - 1; w >= 0; w--) begin
      if (hits[w]) begin
        n_hit  = 1'b1;
        n_cfg  = live[w].cfg;
        n_addr = xaddrs[w];
        n_off  = offs[w];
        n_tgt  = live[w].target;
      end
    end
  end

  assign req_ready = !res_valid || res_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_cfg   <= 1'b0;
      res_addr  <= '0;
      res_bus   <= '0;
      res_devfn <= '0;
      res_reg   <= '0;
    end else if (req_valid && req_ready) begin
      res_valid <= 1'b1;
      res_hit   <= n_hit;
      res_cfg   <= n_hit && n_cfg;
      res_addr  <= (n_hit && !n_cfg) ? n_addr : '0;
      res_bus   <= (n_hit && n_cfg) ? n_tgt[31:24] : '0;
      res_devfn <= (n_hit && n_cfg) ? n_tgt[23:16] : '0;
      res_reg   <= (n_hit && n_cfg) ? n_off[11:0] : '0;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/xwu_checker.sv
module xwu_checker #(
  parameter int NWIN = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr_en,
  input logic [11:0] reg_addr,
  input logic [31:0] reg_wr_data,
  input logic [31:0] reg_rd_data,
  input logic        req_valid,
  input logic        req_ready,
  input logic [63:0] req_addr,
  input logic        res_valid,
  input logic        res_ready,
  input logic        res_hit,
  input logic        res_cfg,
  input logic [63:0] res_addr,
  input logic [7:0]  res_bus,
  input logic [7:0]  res_devfn,
  input logic [11:0] res_reg
);
  localparam int IW = (NWIN > 1) ? $clog2(NWIN) : 1;

  assert_sel_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 12'h900) |-> (reg_rd_data[30:IW] == '0));

  assert_cfg_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_cfg) |-> (res_hit && res_addr == 64'h0));

  assert_miss_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (!res_cfg && res_addr == 64'h0 &&
     res_bus == 8'h0 && res_devfn == 8'h0 && res_reg == 12'h0));

  assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> res_valid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_hit) &&
     $stable(res_cfg) && $stable(res_addr) && $stable(res_reg)));

  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !req_ready);
endmodule

bind xlat_window_unit xwu_checker #(.NWIN(NWIN)) u_chk (.*);

// File: tb/test_xlat_window_unit.sv
module test_xlat_window_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [11:0] reg_addr = 12'h0;
  logic [31:0] reg_wr_data = 32'h0;
  logic [31:0] reg_rd_data;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = 64'h0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_hit, res_cfg;
  logic [63:0] res_addr;
  logic [7:0]  res_bus, res_devfn;
  logic [11:0] res_reg;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  xlat_window_unit #(.NWIN(4)) i_xlat_window_unit (.*);

  // addr, hit, cfg, xaddr, bus, devfn, reg
  localparam int VW = 64 + 1 + 1 + 64 + 8 + 8 + 12;
  localparam int NV = 11;
  localparam logic [VW-1:0] VEC [NV] = '{
    {64'h0000_0000_4000_0000, 1'b1, 1'b0, 64'h0000_0012_3456_0000, 8'h00, 8'h00, 12'h000},
    {64'h0000_0000_4000_FFFF, 1'b1, 1'b0, 64'h0000_0012_3456_FFFF, 8'h00, 8'h00, 12'h000},
    {64'h0000_0000_4000_8000, 1'b1, 1'b0, 64'h0000_0012_3456_8000, 8'h00, 8'h00, 12'h000},
    {64'h0000_0000_4001_0000, 1'b1, 1'b0, 64'h0000_0000_8000_8000, 8'h00, 8'h00, 12'h000},
    {64'h0000_0000_4001_7FFF, 1'b1, 1'b0, 64'h0000_0000_8000_FFFF, 8'h00, 8'h00, 12'h000},
    {64'h0000_0000_4001_8000, 1'b0, 1'b0, 64'h0,                   8'h00, 8'h00, 12'h000},
    {64'h0000_0000_3FFF_FFFF, 1'b0, 1'b0, 64'h0,                   8'h00, 8'h00, 12'h000},
    {64'h0000_0000_5000_0ABC, 1'b1, 1'b1, 64'h0,                   8'h03, 8'h18, 12'hABC},
    {64'h0000_0000_5123_4FFC, 1'b1, 1'b1, 64'h0,                   8'h03, 8'h18, 12'hFFC},
    {64'h0000_0000_6000_0000, 1'b0, 1'b0, 64'h0,                   8'h00, 8'h00, 12'h000},
    {64'h0000_0001_4000_0000, 1'b0, 1'b0, 64'h0,                   8'h00, 8'h00, 12'h000}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, {32'h0, reg_rd_data}, {32'h0, exp});
  endtask

  task automatic lookup(input logic [63:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic prog_win(input int idx, input logic [31:0] ctl1, input logic [31:0] b,
                          input logic [31:0] lim, input logic [31:0] tlo,
                          input logic [31:0] thi, input logic [31:0] ctl2);
    wr(12'h900, 32'(idx));
    wr(12'h904, ctl1);
    wr(12'h90C, b);
    wr(12'h910, 32'h0);
    wr(12'h914, lim);
    wr(12'h918, tlo);
    wr(12'h91C, thi);
    wr(12'h908, ctl2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R4: reset values, outbound window 0 and inbound window 0
    rd_check("R4 select", 12'h900, 32'h0);
    rd_check("R4 base", 12'h90C, 32'h0);
    rd_check("R4 limit", 12'h914, 32'hFFFF_FFFF);
    rd_check("R4 ctl2 out", 12'h908, 32'h0);
    rd_check("R2 unmapped", 12'h920, 32'h0);
    wr(12'h900, 32'h8000_0000);
    rd_check("R4 ctl2 in0", 12'h908, 32'h8000_0000);
    lookup(64'h0);
    check("R4 no hit after reset", {63'h0, res_hit}, 64'h0);
    check("R11 valid", {63'h0, res_valid}, 64'h1);

    // R1: selector masking
    wr(12'h900, 32'hFFFF_FFFF);
    rd_check("R1 select mask", 12'h900, 32'h8000_0003);
    wr(12'h900, 32'h0000_0006);
    rd_check("R1 index mask", 12'h900, 32'h0000_0002);

    // Program outbound windows: 0 mem, 1 cfg, 2 mem overlapping 0, 3 disabled
    prog_win(0, 32'h0, 32'h4000_0000, 32'h4000_FFFF, 32'h3456_0000, 32'h12, 32'h8000_0000);
    prog_win(1, 32'h4, 32'h5000_0000, 32'h5FFF_FFFF, 32'h0318_0000, 32'h0,  32'h8000_0000);
    prog_win(2, 32'h0, 32'h4000_8000, 32'h4001_7FFF, 32'h8000_0000, 32'h0,  32'h8000_0000);
    prog_win(3, 32'h0, 32'h6000_0000, 32'h6FFF_FFFF, 32'h0,         32'h0,  32'h0);

    // R2: readback of selected window 1
    wr(12'h900, 32'h1);
    rd_check("R2 ctl1", 12'h904, 32'h4);
    rd_check("R2 tgt lo", 12'h918, 32'h0318_0000);

    // Table walk: R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      lookup(v[VW-1 -: 64]);
      check("R6 hit", {63'h0, res_hit}, {63'h0, v[93]});
      check("R8 cfg", {63'h0, res_cfg}, {63'h0, v[92]});
      check("R7 addr", res_addr, v[91:28]);
      check("R8 bus", {56'h0, res_bus}, {56'h0, v[27:20]});
      check("R8 devfn", {56'h0, res_devfn}, {56'h0, v[19:12]});
      check("R8 reg", {52'h0, res_reg}, {52'h0, v[11:0]});
    end

    // R3: half updates of base and target
    wr(12'h900, 32'h0);
    wr(12'h910, 32'hAAAA_5555);
    rd_check("R3 base lo kept", 12'h90C, 32'h4000_0000);
    rd_check("R3 base hi", 12'h910, 32'hAAAA_5555);
    wr(12'h910, 32'h0);
    wr(12'h918, 32'h1111_0000);
    rd_check("R3 tgt hi kept", 12'h91C, 32'h12);

    // R5: staged base/target are not live until ctl2 write
    wr(12'h90C, 32'h4400_0000);
    wr(12'h914, 32'h4400_FFFF);
    lookup(64'h4000_0010);
    check("R5 old window still live", res_addr, 64'h12_3456_0010);
    lookup(64'h4400_0010);
    check("R5 new window not yet live", {63'h0, res_hit}, 64'h0);
    wr(12'h908, 32'h8000_0000);
    lookup(64'h4400_0010);
    check("R5 commit hit", res_addr, 64'h12_1111_0010);
    lookup(64'h4000_0010);
    check("R5 old range gone", {63'h0, res_hit}, 64'h0);

    // R12: an enabled inbound window does not affect outbound lookups
    wr(12'h900, 32'h8000_0001);
    wr(12'h90C, 32'h6000_0000);
    wr(12'h914, 32'h6000_FFFF);
    wr(12'h908, 32'h8000_0000);
    rd_check("R12 inbound stored", 12'h908, 32'h8000_0000);
    lookup(64'h6000_0000);
    check("R12 outbound unaffected", {63'h0, res_hit}, 64'h0);

    // R11: back-pressure
    @(negedge clk);
    res_ready = 1'b0; req_valid = 1'b1; req_addr = 64'h4400_0000;
    @(negedge clk);
    req_addr = 64'h5000_0123;
    check("R11 result valid", {63'h0, res_valid}, 64'h1);
    check("R11 stall", {63'h0, req_ready}, 64'h0);
    @(negedge clk);
    check("R11 held addr", res_addr, 64'h12_1111_0000);
    check("R11 still stalled", {63'h0, req_ready}, 64'h0);
    res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 next result cfg", {63'h0, res_cfg}, 64'h1);
    check("R11 next reg", {52'h0, res_reg}, 64'h123);
    @(negedge clk);
    check("R11 drained", {63'h0, res_valid}, 64'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule